// File: doc/BRIEF.md
# Video Control Signal Conditioner

This block sits in front of a serial link framer and cleans up three single-bit video control inputs: data enable, horizontal sync and vertical sync. All three are sampled on the pixel clock. The data enable and horizontal sync channels can optionally pass through a glitch filter. When it is on, a new level has to be present for a minimum number of consecutive clock edges before it reaches the output.

Each channel also has a transition budget over a rolling window of pixel clocks. Data enable and horizontal sync may change at most twice in any window. Vertical sync may change only once, so its pulses are at least one window long. A change that would exceed the budget is held back. The output keeps its level, and a one-cycle flag reports the refusal. The held-back level is applied as soon as budget returns, provided the input still calls for it.

Top module: `vid_ctrl_cond`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `ctrlOut` and `dropPulse` are all zero. Reset also restores every channel's full transition budget.
- R2: The channel bits are assigned as follows: bit 0 is data enable, bit 1 is horizontal sync and bit 2 is vertical sync. Bit 2 is never glitch-filtered, whatever the value of `cfgMode`.
- R3: With `cfgMode` = 2'b01, a new level on bit 0 or bit 1 reaches the output at the third consecutive rising edge that samples it. A pulse seen at fewer than three consecutive edges never appears at the output.
- R4: With `cfgMode` = 2'b00, an output takes a new input level at the first rising edge that samples it, which is one register stage.
- R5: `cfgMode` values 2'b10 and 2'b11 behave exactly like 2'b00.
- R6: Bits 0 and 1 each make at most 2 output transitions in any 130 consecutive clock edges.
- R7: Two consecutive output transitions on bit 2 are at least 130 clock edges apart.
- R8: When a qualified change is refused for lack of budget, three things happen. The output holds its level. `dropPulse` for that channel is high for exactly one cycle, at the edge of the first refusal. It is not raised again while the same request stays pending. If the request is withdrawn and later made again, it pulses again.
- R9: A pending change is applied at the first edge at which the channel's budget is available again.
- R10: The budgets are independent: using up one channel's budget has no effect on the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | 2'b01 turns the glitch filter on for bits 0 and 1; any other value turns it off |
| ctrlIn | input | 3 | Raw control inputs: bit 0 data enable, bit 1 hsync, bit 2 vsync |
| ctrlOut | output | 3 | Conditioned control outputs, same bit order as `ctrlIn` |
| dropPulse | output | 3 | One-cycle flag per channel, raised when a change is refused |

## Verification
The bench sends pulses of one, two, three and more clocks through every configuration value. A filter with an off-by-one count would either pass the two-clock glitch or delay the three-clock pulse by a cycle. Reserved modes treated as "filter on" would swallow single-clock pulses. The bench also toggles a line faster than its budget allows and checks that the refused edge is held until exactly the 130th edge after the first transition. A window one clock too short or too long moves that release edge. A design that re-flags a standing refusal, or fails to re-flag a request that was withdrawn and then made again, gets the wrong pulse count. The vertical sync case checks that this channel keeps the stricter single-transition budget and is never filtered.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int CH_NUM = 3;
  localparam int CH_DE  = 0;
  localparam int CH_HS  = 1;
  localparam int CH_VS  = 2;
  localparam logic [1:0] CFG_FILT = 2'b01;

  // Per-channel command from control to datapath
  typedef struct packed {
    logic flip;   // output takes the opposite level at this edge
    logic drop;   // a qualified change was refused (first cycle only)
  } vcc_strobe_t;
endpackage

// File: rtl/vcc_ctrl.sv
module vcc_ctrl
  import vcc_pkg::*;
#(
  parameter int FILT_LEN   = 3,
  parameter int WIN_LEN    = 130,
  parameter int SLOTS      = 2,
  parameter bit FILTERABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        filtOn,
  input  logic        rawIn,
  input  logic        curOut,
  output vcc_strobe_t strobe
);
  localparam int RUN_W = $clog2(FILT_LEN + 1);
  localparam int TMR_W = $clog2(WIN_LEN);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(FILT_LEN - 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WIN_LEN - 1);

  logic             lastRaw;
  logic [RUN_W-1:0] runCnt;
  logic             blockedQ;
  logic [TMR_W-1:0] tmr [SLOTS];
  logic [SLOTS-1:0] freeVec, pickVec;
  logic             sameLvl, qual, want, anyFree;

  always_comb begin
    sameLvl = (rawIn == lastRaw);
    if (FILTERABLE && filtOn) qual = sameLvl && (runCnt >= RUN_MAX);
    else                      qual = 1'b1;
    want = qual && (rawIn != curOut);
    for (int i = 0; i < SLOTS; i++) freeVec[i] = (tmr[i] == '0);
    pickVec = freeVec & (~freeVec + SLOTS'(1));
    anyFree = |freeVec;
    strobe.flip = want && anyFree;
    strobe.drop = want && !anyFree && !blockedQ;
  end

  // Run-length tracking of the sampled input level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastRaw  <= 1'b0;
      runCnt   <= '0;
      blockedQ <= 1'b0;
    end else begin
      lastRaw  <= rawIn;
      blockedQ <= want && !anyFree;
      if (!sameLvl)              runCnt <= RUN_W'(1);
      else if (runCnt < RUN_MAX) runCnt <= runCnt + RUN_W'(1);
    end
  end

  // One countdown per allowed transition inside the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) tmr[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (strobe.flip && pickVec[i]) tmr[i] <= TMR_LOAD;
        else if (tmr[i] != '0)         tmr[i] <= tmr[i] - TMR_W'(1);
      end
    end
  end
endmodule

// File: rtl/vcc_dpath.sv
module vcc_dpath
  import vcc_pkg::*;
#(
  parameter int CH = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vcc_strobe_t [CH-1:0]   strobes,
  output logic        [CH-1:0]   levelQ,
  output logic        [CH-1:0]   dropQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      dropQ  <= '0;
    end else begin
      for (int i = 0; i < CH; i++) begin
        if (strobes[i].flip) levelQ[i] <= ~levelQ[i];
        dropQ[i] <= strobes[i].drop;
      end
    end
  end
endmodule

// File: rtl/vid_ctrl_cond.sv
module vid_ctrl_cond
  import vcc_pkg::*;
#(
  parameter int FILT_LEN     = 3,
  parameter int WIN_LEN      = 130,
  parameter int LINE_BUDGET  = 2,
  parameter int FRAME_BUDGET = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic [2:0] ctrlIn,
  output logic [2:0] ctrlOut,
  output logic [2:0] dropPulse
);
  logic filtOn;
  vcc_strobe_t [CH_NUM-1:0] strobes;

  assign filtOn = (cfgMode == CFG_FILT);

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
    localparam int SL = (ch == CH_VS) ? FRAME_BUDGET : LINE_BUDGET;
    localparam bit FL = (ch != CH_VS);
    vcc_ctrl #(
      .FILT_LEN(FILT_LEN), .WIN_LEN(WIN_LEN), .SLOTS(SL), .FILTERABLE(FL)
    ) u_ctrl (
      .clk(clk), .rstN(rstN), .filtOn(filtOn),
      .rawIn(ctrlIn[ch]), .curOut(ctrlOut[ch]), .strobe(strobes[ch])
    );
  end

  vcc_dpath #(.CH(CH_NUM)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .levelQ(ctrlOut), .dropQ(dropPulse)
  );
endmodule

// File: rtl/vcc_chk.sv
module vcc_chk #(
  parameter int WIN_LEN = 130
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cfgMode,
  input logic [2:0] ctrlIn,
  input logic [2:0] ctrlOut,
  input logic [2:0] dropPulse
);
  localparam int AGE_W = $clog2(WIN_LEN + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN_LEN);

  logic [2:0]       prevOut;
  logic [2:0]       chg;
  logic [AGE_W-1:0] ageNew [3];
  logic [AGE_W-1:0] ageOld [3];

  assign chg = ctrlOut ^ prevOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut <= '0;
      for (int i = 0; i < 3; i++) begin
        ageNew[i] <= AGE_MAX;
        ageOld[i] <= AGE_MAX;
      end
    end else begin
      prevOut <= ctrlOut;
      for (int i = 0; i < 3; i++) begin
        if (chg[i]) begin
          ageNew[i] <= AGE_W'(1);
          ageOld[i] <= (ageNew[i] < AGE_MAX) ? ageNew[i] + AGE_W'(1) : AGE_MAX;
        end else begin
          if (ageNew[i] < AGE_MAX) ageNew[i] <= ageNew[i] + AGE_W'(1);
          if (ageOld[i] < AGE_MAX) ageOld[i] <= ageOld[i] + AGE_W'(1);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      // R1
      reset_low_chk: assert (ctrlOut == 3'b000 && dropPulse == 3'b000);
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R4
    follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlOut[g] != $past(ctrlOut[g])) |-> (ctrlOut[g] == $past(ctrlIn[g])));
    // R8
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      dropPulse[g] |-> (ctrlOut[g] == $past(ctrlOut[g])));
    // R8
    drop_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      dropPulse[g] |=> !dropPulse[g]);
    if (g < 2) begin : g_line
      // R6
      line_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
        chg[g] |-> (ageOld[g] >= AGE_MAX));
      // R3
      filt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chg[g] && $past(cfgMode) == 2'b01) |->
          ($past(ctrlIn[g], 2) == ctrlOut[g] && $past(ctrlIn[g], 3) == ctrlOut[g]));
    end else begin : g_frame
      // R7
      frame_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        chg[g] |-> (ageNew[g] >= AGE_MAX));
    end
  end
endmodule

bind vid_ctrl_cond vcc_chk #(.WIN_LEN(WIN_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode),
  .ctrlIn(ctrlIn), .ctrlOut(ctrlOut), .dropPulse(dropPulse)
);

// File: tb/sim_vid_ctrl_cond.sv
`timescale 1ns/1ps
module sim_vid_ctrl_cond;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic [2:0] ctrlIn = 3'b000;
  logic [2:0] ctrlOut, dropPulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_ctrl_cond u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode),
    .ctrlIn(ctrlIn), .ctrlOut(ctrlOut), .dropPulse(dropPulse)
  );

  // {cfg[1:0], ch[1:0], width[3:0], firstHigh[3:0], endLevel}
  // firstHigh: negedge count at which the output first reads 1 (0 = never)
  localparam logic [12:0] VECS [0:10] = '{
    {2'b01, 2'd0, 4'd1, 4'd0, 1'b0},  // R3 one-clock glitch removed
    {2'b01, 2'd0, 4'd2, 4'd0, 1'b0},  // R3 two-clock glitch removed
    {2'b01, 2'd0, 4'd3, 4'd3, 1'b0},  // R3 minimum pulse passes
    {2'b01, 2'd1, 4'd2, 4'd0, 1'b0},  // R3 hsync glitch removed
    {2'b01, 2'd1, 4'd5, 4'd3, 1'b0},  // R3 hsync long pulse
    {2'b00, 2'd0, 4'd1, 4'd1, 1'b0},  // R4 unfiltered
    {2'b00, 2'd1, 4'd1, 4'd1, 1'b0},  // R4 unfiltered hsync
    {2'b10, 2'd0, 4'd1, 4'd1, 1'b0},  // R5 reserved mode
    {2'b11, 2'd1, 4'd2, 4'd1, 1'b0},  // R5 reserved mode
    {2'b01, 2'd2, 4'd1, 4'd1, 1'b1},  // R2 vsync never filtered, R7 fall held
    {2'b00, 2'd2, 4'd4, 4'd1, 1'b1}   // R7 fall held
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] cfg);
    @(negedge clk);
    rstN = 1'b0; ctrlIn = 3'b000; cfgMode = cfg;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    @(negedge clk);
    chk(ctrlOut == 3'b000, "R1 out in reset", int'(ctrlOut), 0);
    chk(dropPulse == 3'b000, "R1 drop in reset", int'(dropPulse), 0);
    doReset(2'b00);
    chk(ctrlOut == 3'b000, "R1 out after reset", int'(ctrlOut), 0);
    chk(dropPulse == 3'b000, "R1 drop after reset", int'(dropPulse), 0);

    // Table of single pulses
    for (int v = 0; v < 11; v++) begin
      logic [12:0] e;
      int ch, w, firstHi;
      e = VECS[v];
      ch = int'(e[10:9]); w = int'(e[8:5]); firstHi = 0;
      doReset(e[12:11]);
      ctrlIn[ch] = 1'b1;
      for (int c = 1; c <= 12; c++) begin
        @(negedge clk);
        if (ctrlOut[ch] && firstHi == 0) firstHi = c;
        if (c == w) ctrlIn[ch] = 1'b0;
      end
      chk(firstHi == int'(e[4:1]), $sformatf("R3/R4/R5 vec%0d first high", v),
          firstHi, int'(e[4:1]));
      chk(ctrlOut[ch] == e[0], $sformatf("R2/R7 vec%0d end level", v),
          int'(ctrlOut[ch]), int'(e[0]));
    end

    // Data enable budget: third change held until the window passes
    begin
      int drops = 0;
      doReset(2'b00);
      ctrlIn[0] = 1'b1;
      for (int c = 1; c <= 132; c++) begin
        @(negedge clk);
        if (dropPulse[0]) drops++;
        if (c == 1) chk(ctrlOut[0] == 1'b1, "R4 first rise", int'(ctrlOut[0]), 1);
        if (c == 2) chk(ctrlOut[0] == 1'b0, "R4 fall", int'(ctrlOut[0]), 0);
        if (c == 3) begin
          chk(dropPulse[0] == 1'b1, "R8 refusal flagged", int'(dropPulse[0]), 1);
          chk(ctrlOut[0] == 1'b0, "R8 output holds", int'(ctrlOut[0]), 0);
        end
        if (c == 130) chk(ctrlOut[0] == 1'b0, "R6 still held", int'(ctrlOut[0]), 0);
        if (c == 131) chk(ctrlOut[0] == 1'b1, "R9 released at window end", int'(ctrlOut[0]), 1);
        if (c == 100) chk(ctrlOut[1] == 1'b0 && dropPulse[1] == 1'b0, "R10 hsync untouched",
                          int'({ctrlOut[1], dropPulse[1]}), 0);
        if (c == 1) ctrlIn[0] = 1'b0;
        if (c == 2) ctrlIn[0] = 1'b1;
      end
      chk(drops == 1, "R8 single pulse while pending", drops, 1);
    end

    // Vertical sync: one change per window
    begin
      int drops = 0;
      doReset(2'b00);
      ctrlIn[2] = 1'b1;
      for (int c = 1; c <= 132; c++) begin
        @(negedge clk);
        if (dropPulse[2]) drops++;
        if (c == 1) chk(ctrlOut[2] == 1'b1, "R7 rise", int'(ctrlOut[2]), 1);
        if (c == 2) chk(dropPulse[2] == 1'b1, "R7 fall refused", int'(dropPulse[2]), 1);
        if (c == 130) chk(ctrlOut[2] == 1'b1, "R7 min width", int'(ctrlOut[2]), 1);
        if (c == 131) chk(ctrlOut[2] == 1'b0, "R9 vsync fall released", int'(ctrlOut[2]), 0);
        if (c == 1) ctrlIn[2] = 1'b0;
      end
      chk(drops == 1, "R8 vsync single pulse", drops, 1);
    end

    // Withdrawn request, then a new one: flagged again
    begin
      doReset(2'b00);
      ctrlIn[1] = 1'b1;
      for (int c = 1; c <= 131; c++) begin
        @(negedge clk);
        if (c == 3) chk(dropPulse[1] == 1'b1, "R8 first refusal", int'(dropPulse[1]), 1);
        if (c == 11) chk(dropPulse[1] == 1'b1, "R8 re-request flagged", int'(dropPulse[1]), 1);
        if (c == 12) chk(dropPulse[1] == 1'b0, "R8 one cycle only", int'(dropPulse[1]), 0);
        if (c == 131) chk(ctrlOut[1] == 1'b1, "R9 hsync released", int'(ctrlOut[1]), 1);
        if (c == 1) ctrlIn[1] = 1'b0;
        if (c == 2) ctrlIn[1] = 1'b1;
        if (c == 3) ctrlIn[1] = 1'b0;
        if (c == 10) ctrlIn[1] = 1'b1;
      end
    end

    // Reset restores the budget
    doReset(2'b00);
    ctrlIn[0] = 1'b1;
    @(negedge clk);
    chk(ctrlOut[0] == 1'b1, "R1 budget restored", int'(ctrlOut[0]), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule